// File: doc/BRIEF.md
# AES-128 Next Round Key Unit

This unit derives the next AES-128 round key from the current one. It works on every 128-bit key group held in a vector source operand. A 5-bit round immediate chooses the round constant. The element start index and the element count select which groups are processed. The unit produces one group per clock and returns one 128-bit result write per processed group.

A caller pulses `start_i` while the unit is idle. At that edge the unit captures the key operand and the round immediate. It then streams the results on the write port and ends with a one-cycle completion pulse, which tells the caller to clear its start index. If the element width or the element bounds do not meet the legality rules, the unit does not write anything. It raises a one-cycle illegal pulse instead.

A round number that is out of range never causes a trap. The unit folds it back into range by inverting bit 3.

Top module: `aes128_kx_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `busy_o`, `wr_valid_o`, `illegal_o` and `done_o` are all 0.
- R2: Bit 4 of `rnd_imm_i` has no effect on any result.
- R3: Let n be bits 3:0 of the immediate. If n is 0 or greater than 10, bit 3 of n is inverted. The round-constant index is the adjusted n minus 1. Indices 0..9 select the bytes 01,02,04,08,10,20,40,80,1B,36, and the selected byte is XORed into bits 7:0 of new word 0.
- R4: Word i of a key sits at bits 32i+31:32i. Rotation takes old word 3 with bytes {b3,b2,b1,b0} (b3 in bits 31:24) to {b0,b3,b2,b1}. The unit applies the AES S-box to each byte of the rotated word. New word 0 is that substituted word XOR the round constant XOR old word 0.
- R5: New word 1 equals new word 0 XOR old word 1. New word 2 equals new word 1 XOR old word 2. New word 3 equals new word 2 XOR old word 3.
- R6: A start is illegal when any of these holds: `sew_i` is not 3'b010 (32-bit elements), `vstart_i` is not a multiple of 4, `vl_i` is not a multiple of 4, or `vl_i` exceeds 4*NUM_GROUPS. An illegal start raises `illegal_o` for exactly the next cycle and produces no writes and no `done_o`.
- R7: A legal start with `vstart_i` < `vl_i` writes groups `vstart_i`/4 through `vl_i`/4-1. The writes come one per cycle, in ascending order, starting the cycle after the start. Group g's key is bits 128g+127:128g of `key_src_i`.
- R8: `done_o` pulses for one cycle right after the last write cycle. A legal start with `vstart_i` >= `vl_i` writes nothing and pulses `done_o` in the next cycle. `busy_o` is high exactly during the write cycles.
- R9: A start that arrives while `busy_o` is high is ignored.
- R10: The key operand and the immediate are captured at the accepted start. Later changes to them do not affect the results of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| sew_i | input | 3 | Element width code; 3'b010 means 32-bit |
| vstart_i | input | CNT_W | First element index |
| vl_i | input | CNT_W | Element count |
| rnd_imm_i | input | 5 | Round immediate |
| key_src_i | input | 128*NUM_GROUPS | Current round keys, group g at bits 128g+127:128g |
| busy_o | output | 1 | Operation in progress |
| wr_valid_o | output | 1 | Result write this cycle |
| wr_group_o | output | GRP_W | Group index of the write |
| wr_data_o | output | 128 | Next round key of that group |
| illegal_o | output | 1 | Illegal start pulse |
| done_o | output | 1 | Completion pulse; caller clears its start index |

## Verification
The bench builds the unit with the default of four key groups. With that setting, CNT_W is 5, so element counts up to 31 can be driven. This lets the bench exercise the capacity check (for example, a count of 20) alongside the alignment and element-width checks. Four groups also make room for partial runs that begin part-way through the operand, and for restarts and operand changes injected while a run is still in progress. The immediate is swept across all 32 values, so every folded round number is reached.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

  localparam logic [2:0] SEW_32 = 3'b010;

  typedef enum logic {
    KX_IDLE = 1'b0,
    KX_RUN  = 1'b1
  } kx_state_e;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // forward substitution: inverse as a^254, then affine map
  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = a;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  // round constant: repeated doubling of 1
  function automatic logic [7:0] rcon_byte(input logic [3:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < 15; i++) begin
      if (i < int'(idx)) r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

endpackage

// File: rtl/kx_round_sel.sv
module kx_round_sel (
  input  logic [3:0] imm_i,
  output logic [3:0] idx_o,
  output logic [7:0] rcon_o
);
  import aes_kx_pkg::*;

  logic       fold;
  logic [3:0] fixed;

  always_comb begin
    fold   = (imm_i == 4'd0) || (imm_i > 4'd10);
    fixed  = {imm_i[3] ^ fold, imm_i[2:0]};
    idx_o  = fixed - 4'd1;
    rcon_o = rcon_byte(idx_o);
  end

endmodule

// File: rtl/kx_sbox.sv
module kx_sbox (
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  import aes_kx_pkg::*;

  always_comb y_o = sbox_fwd(a_i);

endmodule

// File: rtl/kx_next_key.sv
module kx_next_key #(
  parameter int WORDS = 4,
  localparam int KW  = 32 * WORDS
) (
  input  logic [KW-1:0] key_i,
  input  logic [7:0]    rcon_i,
  output logic [KW-1:0] key_o
);

  logic [31:0] top_word;
  logic [31:0] rot_word;
  logic [31:0] sub_word;
  logic [WORDS-1:0][31:0] old_w;
  logic [WORDS-1:0][31:0] new_w;

  assign old_w    = key_i;
  assign top_word = old_w[WORDS-1];
  assign rot_word = {top_word[7:0], top_word[31:8]};

  for (genvar b = 0; b < 4; b++) begin : g_sub
    kx_sbox u_sbox (
      .a_i (rot_word[8*b +: 8]),
      .y_o (sub_word[8*b +: 8])
    );
  end

  assign new_w[0] = sub_word ^ {24'h0, rcon_i} ^ old_w[0];

  for (genvar w = 1; w < WORDS; w++) begin : g_chain
    assign new_w[w] = new_w[w-1] ^ old_w[w];
  end

  assign key_o = new_w;

endmodule

// File: rtl/kx_group_seq.sv
module kx_group_seq #(
  parameter int NUM_GROUPS = 4,
  localparam int ELEMS = 4 * NUM_GROUPS,
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int CNT_W = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       sew_i,
  input  logic [CNT_W-1:0] vstart_i,
  input  logic [CNT_W-1:0] vl_i,
  output logic             busy_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             capture_o,
  output logic             illegal_o,
  output logic             done_o
);
  import aes_kx_pkg::*;

  kx_state_e        state_q, state_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [GRP_W-1:0] last_q, last_d;
  logic             ill_q, ill_d;
  logic             done_q, done_d;

  logic accept;
  logic legal;
  logic empty;

  always_comb begin
    accept = start_i && (state_q == KX_IDLE);
    legal  = (sew_i == SEW_32) && (vstart_i[1:0] == 2'b00) &&
             (vl_i[1:0] == 2'b00) && (int'(vl_i) <= ELEMS);
    empty  = (vstart_i >= vl_i);
  end

  always_comb begin
    state_d   = state_q;
    grp_d     = grp_q;
    last_d    = last_q;
    ill_d     = 1'b0;
    done_d    = 1'b0;
    capture_o = 1'b0;
    case (state_q)
      KX_IDLE: begin
        if (accept) begin
          if (!legal) begin
            ill_d = 1'b1;
          end else if (empty) begin
            done_d = 1'b1;
          end else begin
            capture_o = 1'b1;
            state_d   = KX_RUN;
            grp_d     = vstart_i[GRP_W+1:2];
            last_d    = vl_i[GRP_W+1:2] - GRP_W'(1);
          end
        end
      end
      KX_RUN: begin
        if (grp_q == last_q) begin
          state_d = KX_IDLE;
          done_d  = 1'b1;
        end else begin
          grp_d = grp_q + GRP_W'(1);
        end
      end
      default: state_d = KX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KX_IDLE;
      grp_q   <= '0;
      last_q  <= '0;
      ill_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      last_q  <= last_d;
      ill_q   <= ill_d;
      done_q  <= done_d;
    end
  end

  assign busy_o    = (state_q == KX_RUN);
  assign grp_o     = grp_q;
  assign illegal_o = ill_q;
  assign done_o    = done_q;

endmodule

// File: rtl/aes128_kx_unit.sv
module aes128_kx_unit #(
  parameter int NUM_GROUPS = 4,
  localparam int KEY_W = 128 * NUM_GROUPS,
  localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int CNT_W = $clog2(4 * NUM_GROUPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       sew_i,
  input  logic [CNT_W-1:0] vstart_i,
  input  logic [CNT_W-1:0] vl_i,
  input  logic [4:0]       rnd_imm_i,
  input  logic [KEY_W-1:0] key_src_i,
  output logic             busy_o,
  output logic             wr_valid_o,
  output logic [GRP_W-1:0] wr_group_o,
  output logic [127:0]     wr_data_o,
  output logic             illegal_o,
  output logic             done_o
);

  logic                        capture;
  logic [NUM_GROUPS-1:0][127:0] key_q;
  logic [3:0]                  rnd_q;
  logic [3:0]                  rnd_idx_w;
  logic [7:0]                  rcon_w;
  logic [127:0]                grp_key;
  logic                        imm_bit4_unused;

  assign imm_bit4_unused = rnd_imm_i[4];

  kx_group_seq #(.NUM_GROUPS(NUM_GROUPS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sew_i     (sew_i),
    .vstart_i  (vstart_i),
    .vl_i      (vl_i),
    .busy_o    (busy_o),
    .grp_o     (wr_group_o),
    .capture_o (capture),
    .illegal_o (illegal_o),
    .done_o    (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      rnd_q <= '0;
    end else if (capture) begin
      key_q <= key_src_i;
      rnd_q <= rnd_imm_i[3:0];
    end
  end

  assign grp_key = key_q[wr_group_o];

  kx_round_sel u_rnd (
    .imm_i  (rnd_q),
    .idx_o  (rnd_idx_w),
    .rcon_o (rcon_w)
  );

  kx_next_key #(.WORDS(4)) u_key (
    .key_i  (grp_key),
    .rcon_i (rcon_w),
    .key_o  (wr_data_o)
  );

  assign wr_valid_o = busy_o;

endmodule

// File: rtl/kx_unit_chk.sv
module kx_unit_chk #(
  parameter int GRP_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             wr_valid_o,
  input logic [GRP_W-1:0] wr_group_o,
  input logic             illegal_o,
  input logic             done_o,
  input logic [3:0]       rnd_idx
);

  // R3
  rcon_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rnd_idx <= 4'd9));

  // R6
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!wr_valid_o && !done_o && !busy_o));

  // R7
  write_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && $past(wr_valid_o)) |-> (wr_group_o == $past(wr_group_o) + GRP_W'(1)));

  // R8
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

bind aes128_kx_unit kx_unit_chk #(.GRP_W(GRP_W)) u_kx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .wr_valid_o (wr_valid_o),
  .wr_group_o (wr_group_o),
  .illegal_o  (illegal_o),
  .done_o     (done_o),
  .rnd_idx    (rnd_idx_w)
);

// File: tb/test_aes128_kx_unit.sv
module test_aes128_kx_unit;

  localparam int NG = 4;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                start;
  logic [2:0]          sew;
  logic [4:0]          vstart;
  logic [4:0]          vlv;
  logic [4:0]          imm_r;
  logic [NG-1:0][127:0] key_src;
  logic                busy, wr_valid, illegal, done;
  logic [1:0]          wr_group;
  logic [127:0]        wr_data;

  always #4 clk = ~clk;

  aes128_kx_unit #(.NUM_GROUPS(NG)) i_aes128_kx_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .sew_i      (sew),
    .vstart_i   (vstart),
    .vl_i       (vlv),
    .rnd_imm_i  (imm_r),
    .key_src_i  (key_src),
    .busy_o     (busy),
    .wr_valid_o (wr_valid),
    .wr_group_o (wr_group),
    .wr_data_o  (wr_data),
    .illegal_o  (illegal),
    .done_o     (done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] sb [256];
  logic [7:0] rc_tab [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                              8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  function automatic logic [127:0] ref_next(input logic [127:0] k, input logic [4:0] im);
    int n;
    logic [31:0] t, r, s;
    logic [31:0] w [4];
    n = int'(im[3:0]);
    if (n == 0 || n > 10) n = n ^ 8;
    t = k[127:96];
    r = {t[7:0], t[31:24], t[23:16], t[15:8]};
    s = {sb[r[31:24]], sb[r[23:16]], sb[r[15:8]], sb[r[7:0]]};
    w[0] = s ^ {24'h0, rc_tab[n-1]} ^ k[31:0];
    w[1] = w[0] ^ k[63:32];
    w[2] = w[1] ^ k[95:64];
    w[3] = w[2] ^ k[127:96];
    return {w[3], w[2], w[1], w[0]};
  endfunction

  // reference model, advanced on every rising edge
  bit m_busy, m_ill, m_done;
  int m_grp, m_last;
  logic [NG-1:0][127:0] m_key;
  logic [4:0] m_imm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ill = 0; m_done = 0; m_grp = 0; m_last = 0;
    end else begin
      m_ill = 0;
      m_done = 0;
      if (m_busy) begin
        if (m_grp == m_last) begin m_busy = 0; m_done = 1; end
        else m_grp++;
      end else if (start) begin
        if (sew != 3'b010 || vstart % 4 != 0 || vlv % 4 != 0 || int'(vlv) > 4 * NG)
          m_ill = 1;
        else if (vstart >= vlv)
          m_done = 1;
        else begin
          m_busy = 1; m_grp = vstart / 4; m_last = vlv / 4 - 1;
          m_key = key_src; m_imm = imm_r;
        end
      end
    end
  end

  // per-cycle comparison and result capture
  logic [127:0] got [NG];
  int wr_cnt, ill_cnt, done_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 busy", 128'(busy), 128'(0));
      chk("R1 valid", 128'(wr_valid), 128'(0));
      chk("R1 illegal", 128'(illegal), 128'(0));
      chk("R1 done", 128'(done), 128'(0));
    end else if (!finished) begin
      chk("R8 busy", 128'(busy), 128'(m_busy));
      chk("R7 valid", 128'(wr_valid), 128'(m_busy));
      if (m_busy) begin
        chk("R7 group", 128'(wr_group), 128'(m_grp));
        chk("R4 R5 data", wr_data, ref_next(m_key[m_grp], m_imm));
      end
      chk("R6 illegal", 128'(illegal), 128'(m_ill));
      chk("R8 done", 128'(done), 128'(m_done));
      if (wr_valid) begin got[wr_group] = wr_data; wr_cnt++; end
      if (illegal) ill_cnt++;
      if (done) done_cnt++;
    end
  end

  task automatic do_op(input logic [2:0] s, input int vs, input int vl, input int im, input bit poke);
    @(negedge clk);
    wr_cnt = 0; ill_cnt = 0; done_cnt = 0;
    for (int g = 0; g < NG; g++) got[g] = '0;
    sew = s; vstart = vs[4:0]; vlv = vl[4:0]; imm_r = im[4:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9/R10: restart and operand change while busy
      start = 1'b1; imm_r = imm_r ^ 5'h07; key_src = ~key_src;
    end
    @(negedge clk);
    start = 1'b0;
    repeat (NG + 3) @(negedge clk);
  endtask

  logic [127:0] res [32];
  logic [NG-1:0][127:0] saved;

  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    for (int n = 0; n < 255; n++) begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sb[p] = x ^ 8'h63;
    end
    sb[0] = 8'h63;

    rst_n = 1'b1; start = 1'b0; sew = 3'b010; vstart = '0; vlv = '0; imm_r = '0;
    key_src = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after release
    @(negedge clk);
    chk("R1 busy after release", 128'(busy), 128'(0));
    chk("R1 done after release", 128'(done), 128'(0));

    // R4/R5 known answer, first expansion round
    key_src[0] = {32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b};
    do_op(3'b010, 0, 4, 1, 0);
    chk("R4 word0", 128'(got[0][31:0]), 128'(32'h17fefaa0));
    chk("R5 words1-3", 128'(got[0][127:32]), 128'({32'h05766c2a, 32'h3939a323, 32'hb12c5488}));

    // R7: full operand
    for (int g = 0; g < NG; g++) key_src[g] = {$urandom, $urandom, $urandom, $urandom};
    do_op(3'b010, 0, 16, 5, 0);
    chk("R7 count full", 128'(wr_cnt), 128'(4));
    for (int g = 0; g < NG; g++) chk("R7 group data", got[g], ref_next(key_src[g], 5'd5));
    chk("R8 done full", 128'(done_cnt), 128'(1));

    // R7: start part-way
    do_op(3'b010, 8, 16, 2, 0);
    chk("R7 count partial", 128'(wr_cnt), 128'(2));
    chk("R7 skipped group", got[0], 128'(0));

    // R2/R3: immediate sweep
    for (int i = 0; i < 32; i++) begin
      do_op(3'b010, 0, 4, i, 0);
      res[i] = got[0];
    end
    chk("R3 fold 0->8", res[0], res[8]);
    chk("R3 fold 11->3", res[11], res[3]);
    chk("R3 fold 15->7", res[15], res[7]);
    chk("R3 rcon 36", 128'(res[10][7:0] ^ res[1][7:0]), 128'(8'h37));
    for (int i = 0; i < 16; i++) chk("R2 bit4", res[i + 16], res[i]);

    // R6: illegal starts
    do_op(3'b011, 0, 4, 1, 0);
    chk("R6 sew ill", 128'(ill_cnt), 128'(1));
    chk("R6 sew writes", 128'(wr_cnt + done_cnt), 128'(0));
    do_op(3'b010, 2, 8, 1, 0);
    chk("R6 vstart ill", 128'(ill_cnt), 128'(1));
    do_op(3'b010, 0, 6, 1, 0);
    chk("R6 vl ill", 128'(ill_cnt), 128'(1));
    do_op(3'b010, 0, 20, 1, 0);
    chk("R6 capacity ill", 128'(ill_cnt), 128'(1));
    chk("R6 capacity writes", 128'(wr_cnt + done_cnt), 128'(0));

    // R8: empty ranges
    do_op(3'b010, 8, 8, 1, 0);
    chk("R8 empty done", 128'(done_cnt), 128'(1));
    chk("R8 empty writes", 128'(wr_cnt), 128'(0));
    do_op(3'b010, 12, 4, 1, 0);
    chk("R8 reversed done", 128'(done_cnt), 128'(1));

    // R9/R10: restart and operand change during run
    saved = key_src;
    do_op(3'b010, 0, 16, 4, 1);
    chk("R9 count", 128'(wr_cnt), 128'(4));
    chk("R9 done", 128'(done_cnt), 128'(1));
    for (int g = 0; g < NG; g++) chk("R10 captured", got[g], ref_next(saved[g], 5'd4));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule